// File: doc/BRIEF.md
# BCD Calendar Time Counter

This block keeps wall-clock time and date in eight byte-wide fields: seconds, minutes, hours, day of week, day of month, month, two-digit year and century. A prescaler counts enable pulses from a 32.768 kHz time base. Once per second it advances the fields through a full Gregorian carry chain. Each field is held either as two BCD digits or as plain binary. The hour field can use a 24-hour form, or a 12-hour form in which bit 7 marks afternoon. A separate register controller owns the host bus. It drives the mode and control inputs and loads fields through a one-byte load port. Alarm comparison lives outside this block and watches the field outputs and the update pulse.

The prescaler is a three-state machine. DIV_HALT holds the prescaler at half a second while the divider-reset code is present. DIV_STOP freezes the prescaler where it stands, and is used when the freeze bit is set or the divider code is not one of the running codes. DIV_RUN counts ticks. The next state is decoded from the control inputs on every cycle. From any state, the machine moves to DIV_HALT when control bits [2:1] are both 1. Otherwise it moves to DIV_RUN when freeze is 0 and the control code is 3'b010 or lower. In every other case it moves to DIV_STOP. The state register applies the choice at the next clock edge, so a control change takes effect one cycle later. In DIV_RUN, the last tick of each second is the rollover. At that edge the fields advance, the prescaler returns to zero and a one-cycle update pulse is registered.

Top module: `rtc_cal_counter`

## Requirements
- R1: After reset the fields read, from century down to seconds: 0x20, 0x00, 0x01, 0x01, 0x01, 0x00, 0x00, 0x00. After reset, uip_o and upd_pulse_o are 0.
- R2: While running with tick_en high on every cycle, upd_pulse_o is high for exactly one cycle once every TICKS_PER_SEC cycles.
- R3: uip_o is high for the last UIP_TICKS ticks before each rollover, and is 0 in the cycle where upd_pulse_o is 1.
- R4: When ctl_freeze is 1, or ctl_div is above 3'b010 without being a halt code, no update pulse occurs, uip_o is 0 and every field keeps its value.
- R5: When ctl_div[2:1] is 2'b11 the divider is halted, uip_o is 0 and no update occurs. After ctl_div returns to 3'b010, the first pulse appears TICKS_PER_SEC/2 + 1 cycles later.
- R6: With ctl_binary at 0, every field holds two BCD digits (tens in [7:4], units in [3:0]). With ctl_binary at 1, every field holds its value in plain binary. The stored bytes are reinterpreted and not converted when the mode changes.
- R7: With ctl_24h at 0, the hour field holds 1 to 12 with bit 7 set for afternoon hours. Midnight is 12 with bit 7 clear and noon is 12 with bit 7 set. With ctl_24h at 1 it holds 0 to 23.
- R8: Seconds wrap from 59 to 0 and carry into minutes. Minutes wrap from 59 to 0 and carry into hours. Hours wrap from 23 to 0 and carry into the day. Day of week runs 1 to 7 and wraps to 1. Month lengths are Gregorian, with February having 29 days when the year is divisible by 4. Month 12 wraps to 1. Year 99 wraps to 0 and advances the century modulo 100.
- R9: ld_en writes ld_data into the field chosen by ld_sel at the next edge: 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 day of month, 5 month, 6 year, 7 century. A loaded value is kept while the counter is frozen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle enable per time-base tick |
| ctl_div | input | 3 | Divider control code |
| ctl_freeze | input | 1 | Freeze updates so fields can be loaded |
| ctl_binary | input | 1 | 1: binary fields, 0: BCD fields |
| ctl_24h | input | 1 | 1: 24-hour, 0: 12-hour with PM bit |
| ld_en | input | 1 | Field load strobe |
| ld_sel | input | 3 | Field index for a load |
| ld_data | input | 8 | Byte to load |
| sec_o | output | 8 | Seconds field |
| min_o | output | 8 | Minutes field |
| hour_o | output | 8 | Hours field |
| wday_o | output | 8 | Day-of-week field |
| mday_o | output | 8 | Day-of-month field |
| mon_o | output | 8 | Month field |
| year_o | output | 8 | Year field (two low digits) |
| cent_o | output | 8 | Century field |
| uip_o | output | 1 | Update about to occur |
| upd_pulse_o | output | 1 | One-cycle pulse at each rollover |

## Verification
The properties assume a second of at least two ticks, so that two pulses can never be adjacent. They also assume that control inputs change only between clock edges, with each change picked up by the state register one edge later. The load property assumes that a load always beats a same-cycle rollover for the addressed field. The bench changes controls and loads fields only on the falling edge. It loads fields only while the counter is frozen or halted, and it checks pulse spacing and the UIP window only across seconds that its own control changes have not cut short.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

    localparam int NFLD = 8;

    typedef enum logic [2:0] {
        FLD_SEC  = 3'd0,
        FLD_MIN  = 3'd1,
        FLD_HOUR = 3'd2,
        FLD_WDAY = 3'd3,
        FLD_MDAY = 3'd4,
        FLD_MON  = 3'd5,
        FLD_YEAR = 3'd6,
        FLD_CENT = 3'd7
    } fld_e;

    typedef enum logic [1:0] {
        DIV_STOP = 2'd0,
        DIV_HALT = 2'd1,
        DIV_RUN  = 2'd2
    } div_state_e;

    // Stored byte to numeric value under the current storage mode
    function automatic logic [7:0] dec_val(input logic [7:0] raw, input logic bin);
        if (bin)
            return raw;
        return ({4'd0, raw[7:4]} * 8'd10) + {4'd0, raw[3:0]};
    endfunction

    // Numeric value to stored byte under the current storage mode
    function automatic logic [7:0] enc_val(input logic [7:0] v, input logic bin);
        logic [7:0] tens;
        logic [7:0] units;
        tens  = v / 8'd10;
        units = v % 8'd10;
        if (bin)
            return v;
        return {tens[3:0], units[3:0]};
    endfunction

    function automatic logic [7:0] rst_byte(input int idx);
        case (idx)
            3, 4, 5: return 8'h01;
            7:       return 8'h20;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/rtc_div_fsm.sv
module rtc_div_fsm
    import rtc_cal_pkg::*;
#(
    parameter int TICKS_PER_SEC = 32768,
    parameter int UIP_TICKS     = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_en,
    input  logic [2:0] ctl_div,
    input  logic       ctl_freeze,
    output logic       roll,
    output logic       uip,
    output logic       upd_pulse
);

    localparam int CW = $clog2(TICKS_PER_SEC);
    localparam logic [CW-1:0] LAST     = CW'(TICKS_PER_SEC - 1);
    localparam logic [CW-1:0] HALF     = CW'(TICKS_PER_SEC / 2);
    localparam logic [CW-1:0] UIP_FROM = CW'(TICKS_PER_SEC - UIP_TICKS);

    div_state_e      st_q, st_d;
    logic [CW-1:0]   cnt_q;

    // Next-state decode from the control inputs
    always_comb begin
        if (ctl_div[2:1] == 2'b11)
            st_d = DIV_HALT;
        else if (!ctl_freeze && (ctl_div <= 3'b010))
            st_d = DIV_RUN;
        else
            st_d = DIV_STOP;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= DIV_STOP;
        else
            st_q <= st_d;
    end

    assign roll = (st_q == DIV_RUN) && tick_en && (cnt_q == LAST);

    // Prescaler action per state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            unique case (st_q)
                DIV_HALT: cnt_q <= HALF;
                DIV_RUN:  if (tick_en) cnt_q <= roll ? '0 : cnt_q + 1'b1;
                DIV_STOP: cnt_q <= cnt_q;
                default:  cnt_q <= cnt_q;
            endcase
        end
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            upd_pulse <= 1'b0;
        else
            upd_pulse <= roll;
    end

    assign uip = (st_q == DIV_RUN) && (cnt_q >= UIP_FROM);

endmodule

// File: rtl/rtc_cal_next.sv
module rtc_cal_next
    import rtc_cal_pkg::*;
(
    input  logic [NFLD-1:0][7:0] cur,
    input  logic                 bin_mode,
    input  logic                 h24,
    output logic [NFLD-1:0][7:0] nxt
);

    logic [7:0] s, m, h, wd, md, mo, yr, ce, hv, dim;
    logic [7:0] hn, hh;
    logic       c_s, c_m, c_h, c_md, c_mo, c_yr;

    function automatic logic [7:0] days_in(input logic [7:0] mon, input logic [7:0] year);
        case (mon)
            8'd2:                     return (year[1:0] == 2'b00) ? 8'd29 : 8'd28;
            8'd4, 8'd6, 8'd9, 8'd11:  return 8'd30;
            default:                  return 8'd31;
        endcase
    endfunction

    always_comb begin
        s  = dec_val(cur[FLD_SEC],  bin_mode);
        m  = dec_val(cur[FLD_MIN],  bin_mode);
        wd = dec_val(cur[FLD_WDAY], bin_mode);
        md = dec_val(cur[FLD_MDAY], bin_mode);
        mo = dec_val(cur[FLD_MON],  bin_mode);
        yr = dec_val(cur[FLD_YEAR], bin_mode);
        ce = dec_val(cur[FLD_CENT], bin_mode);

        // Hour to 0..23
        if (h24) begin
            h  = dec_val(cur[FLD_HOUR], bin_mode);
            hv = 8'd0;
        end else begin
            hv = dec_val({1'b0, cur[FLD_HOUR][6:0]}, bin_mode);
            h  = ((hv == 8'd12) ? 8'd0 : hv) + (cur[FLD_HOUR][7] ? 8'd12 : 8'd0);
        end

        dim  = days_in(mo, yr);
        c_s  = (s >= 8'd59);
        c_m  = c_s && (m >= 8'd59);
        c_h  = c_m && (h >= 8'd23);
        c_md = c_h && (md >= dim);
        c_mo = c_md && (mo >= 8'd12);
        c_yr = c_mo && (yr >= 8'd99);

        hn = c_h ? 8'd0 : h + 8'd1;
        if (hn == 8'd0)
            hh = 8'd12;
        else if (hn > 8'd12)
            hh = hn - 8'd12;
        else
            hh = hn;

        nxt = cur;
        nxt[FLD_SEC] = enc_val(c_s ? 8'd0 : s + 8'd1, bin_mode);
        if (c_s)
            nxt[FLD_MIN] = enc_val(c_m ? 8'd0 : m + 8'd1, bin_mode);
        if (c_m)
            nxt[FLD_HOUR] = h24 ? enc_val(hn, bin_mode)
                                : (enc_val(hh, bin_mode) | {(hn >= 8'd12), 7'd0});
        if (c_h) begin
            nxt[FLD_WDAY] = enc_val((wd >= 8'd7) ? 8'd1 : wd + 8'd1, bin_mode);
            nxt[FLD_MDAY] = enc_val(c_md ? 8'd1 : md + 8'd1, bin_mode);
        end
        if (c_md)
            nxt[FLD_MON] = enc_val(c_mo ? 8'd1 : mo + 8'd1, bin_mode);
        if (c_mo)
            nxt[FLD_YEAR] = enc_val(c_yr ? 8'd0 : yr + 8'd1, bin_mode);
        if (c_yr)
            nxt[FLD_CENT] = enc_val((ce >= 8'd99) ? 8'd0 : ce + 8'd1, bin_mode);
    end

endmodule

// File: rtl/rtc_cal_counter.sv
module rtc_cal_counter
    import rtc_cal_pkg::*;
#(
    parameter int TICKS_PER_SEC = 32768,
    parameter int UIP_TICKS     = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_en,
    input  logic [2:0] ctl_div,
    input  logic       ctl_freeze,
    input  logic       ctl_binary,
    input  logic       ctl_24h,
    input  logic       ld_en,
    input  logic [2:0] ld_sel,
    input  logic [7:0] ld_data,
    output logic [7:0] sec_o,
    output logic [7:0] min_o,
    output logic [7:0] hour_o,
    output logic [7:0] wday_o,
    output logic [7:0] mday_o,
    output logic [7:0] mon_o,
    output logic [7:0] year_o,
    output logic [7:0] cent_o,
    output logic       uip_o,
    output logic       upd_pulse_o
);

    logic                 roll;
    logic [NFLD-1:0][7:0] fld_q;
    logic [NFLD-1:0][7:0] fld_nxt;

    rtc_div_fsm #(
        .TICKS_PER_SEC (TICKS_PER_SEC),
        .UIP_TICKS     (UIP_TICKS)
    ) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_en    (tick_en),
        .ctl_div    (ctl_div),
        .ctl_freeze (ctl_freeze),
        .roll       (roll),
        .uip        (uip_o),
        .upd_pulse  (upd_pulse_o)
    );

    rtc_cal_next u_next (
        .cur      (fld_q),
        .bin_mode (ctl_binary),
        .h24      (ctl_24h),
        .nxt      (fld_nxt)
    );

    // A load beats the rollover for the addressed field only
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NFLD; i++)
                fld_q[i] <= rst_byte(i);
        end else begin
            for (int i = 0; i < NFLD; i++) begin
                if (ld_en && (ld_sel == 3'(i)))
                    fld_q[i] <= ld_data;
                else if (roll)
                    fld_q[i] <= fld_nxt[i];
            end
        end
    end

    assign sec_o  = fld_q[FLD_SEC];
    assign min_o  = fld_q[FLD_MIN];
    assign hour_o = fld_q[FLD_HOUR];
    assign wday_o = fld_q[FLD_WDAY];
    assign mday_o = fld_q[FLD_MDAY];
    assign mon_o  = fld_q[FLD_MON];
    assign year_o = fld_q[FLD_YEAR];
    assign cent_o = fld_q[FLD_CENT];

endmodule

// File: rtl/rtc_cal_chk.sv
module rtc_cal_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] ctl_div,
    input logic       ctl_freeze,
    input logic       ld_en,
    input logic [2:0] ld_sel,
    input logic [7:0] ld_data,
    input logic [7:0] sec_o,
    input logic       uip_o,
    input logic       upd_pulse_o
);

    // R3
    uip_low_on_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_pulse_o |-> !uip_o);

    // R2
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_pulse_o |=> !upd_pulse_o);

    // R4
    freeze_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ctl_freeze) |=> !upd_pulse_o);

    // R4
    freeze_no_uip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_freeze |=> !uip_o);

    // R5
    halt_no_uip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_div[2:1] == 2'b11) |=> !uip_o);

    // R9
    load_sec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_en && (ld_sel == 3'd0)) |=> (sec_o == $past(ld_data)));

endmodule

bind rtc_cal_counter rtc_cal_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl_div     (ctl_div),
    .ctl_freeze  (ctl_freeze),
    .ld_en       (ld_en),
    .ld_sel      (ld_sel),
    .ld_data     (ld_data),
    .sec_o       (sec_o),
    .uip_o       (uip_o),
    .upd_pulse_o (upd_pulse_o)
);

// File: tb/rtc_cal_counter_tb.sv
module rtc_cal_counter_tb;

    localparam int TICKS = 64;
    localparam int UIPN  = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b1;
    logic [2:0] ctl_div = 3'b010;
    logic       ctl_freeze = 1'b1;
    logic       ctl_binary = 1'b0;
    logic       ctl_24h = 1'b1;
    logic       ld_en = 1'b0;
    logic [2:0] ld_sel = 3'd0;
    logic [7:0] ld_data = 8'd0;
    logic [7:0] sec_o, min_o, hour_o, wday_o, mday_o, mon_o, year_o, cent_o;
    logic       uip_o, upd_pulse_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit run_mon = 1'b0;
    bit steady  = 1'b0;
    int gap = 0;
    int uip_run = 0;
    string tag = "R8";
    logic [63:0] exp_q[$];

    // reference model, binary values
    int m_s, m_m, m_h, m_wd, m_md, m_mo, m_yr, m_ce;

    always #4 clk = ~clk;

    rtc_cal_counter #(.TICKS_PER_SEC(TICKS), .UIP_TICKS(UIPN)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .ctl_div(ctl_div),
        .ctl_freeze(ctl_freeze), .ctl_binary(ctl_binary), .ctl_24h(ctl_24h),
        .ld_en(ld_en), .ld_sel(ld_sel), .ld_data(ld_data),
        .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .wday_o(wday_o),
        .mday_o(mday_o), .mon_o(mon_o), .year_o(year_o), .cent_o(cent_o),
        .uip_o(uip_o), .upd_pulse_o(upd_pulse_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] enc(input int v);
        if (ctl_binary) return 8'(v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic logic [7:0] enc_hour(input int v);
        int h12;
        if (ctl_24h) return enc(v);
        h12 = (v % 12 == 0) ? 12 : v % 12;
        return enc(h12) | ((v >= 12) ? 8'h80 : 8'h00);
    endfunction

    function automatic logic [63:0] model_snap();
        return {enc(m_ce), enc(m_yr), enc(m_mo), enc(m_md), enc(m_wd),
                enc_hour(m_h), enc(m_m), enc(m_s)};
    endfunction

    function automatic logic [63:0] dut_snap();
        return {cent_o, year_o, mon_o, mday_o, wday_o, hour_o, min_o, sec_o};
    endfunction

    function automatic int month_len(input int mo, input int yr);
        if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    task automatic model_step();
        m_s++;
        if (m_s < 60) return;
        m_s = 0; m_m++;
        if (m_m < 60) return;
        m_m = 0; m_h++;
        if (m_h < 24) return;
        m_h = 0;
        m_wd = (m_wd >= 7) ? 1 : m_wd + 1;
        m_md++;
        if (m_md <= month_len(m_mo, m_yr)) return;
        m_md = 1; m_mo++;
        if (m_mo <= 12) return;
        m_mo = 1; m_yr++;
        if (m_yr <= 99) return;
        m_yr = 0; m_ce = (m_ce + 1) % 100;
    endtask

    // driver: push predicted snapshots
    task automatic predict(input int n);
        for (int i = 0; i < n; i++) begin
            model_step();
            exp_q.push_back(model_snap());
        end
    endtask

    task automatic load_one(input int sel, input logic [7:0] b);
        @(negedge clk);
        ld_en = 1'b1; ld_sel = 3'(sel); ld_data = b;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic load_all(input int s, input int mi, input int h, input int wd,
                            input int md, input int mo, input int yr, input int ce);
        m_s = s; m_m = mi; m_h = h; m_wd = wd; m_md = md; m_mo = mo; m_yr = yr; m_ce = ce;
        load_one(0, enc(s));
        load_one(1, enc(mi));
        load_one(2, enc_hour(h));
        load_one(3, enc(wd));
        load_one(4, enc(md));
        load_one(5, enc(mo));
        load_one(6, enc(yr));
        load_one(7, enc(ce));
        @(negedge clk);
        chk(dut_snap() == model_snap(), "R9", "fields after load", dut_snap(), model_snap());
    endtask

    task automatic wait_drain();
        for (int i = 0; i < 8 * TICKS && exp_q.size() != 0; i++)
            @(negedge clk);
        chk(exp_q.size() == 0, tag, "pending updates", 64'(exp_q.size()), 64'd0);
    endtask

    // monitor: pop and compare at each update pulse
    always @(negedge clk) begin
        if (rst_n && run_mon) begin
            gap++;
            if (upd_pulse_o) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R4", "unexpected update pulse", dut_snap(), 64'd0);
                end else begin
                    logic [63:0] e;
                    e = exp_q.pop_front();
                    chk(dut_snap() == e, tag, "snapshot", dut_snap(), e);
                end
                chk(!uip_o, "R3", "uip in pulse cycle", 64'(uip_o), 64'd0);
                if (steady) begin
                    chk(uip_run == UIPN, "R3", "uip window", 64'(uip_run), 64'(UIPN));
                    chk(gap == TICKS, "R2", "pulse spacing", 64'(gap), 64'(TICKS));
                end
                steady = 1'b1;
                gap = 0;
                uip_run = 0;
            end else if (uip_o) begin
                uip_run++;
            end else begin
                uip_run = 0;
            end
        end
    end

    initial begin
        #(200000 * 8);
        chk(1'b0, "R2", "watchdog expired", 64'd0, 64'd1);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int k;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(dut_snap() == 64'h2000010101000000, "R1", "reset fields", dut_snap(), 64'h2000010101000000);
        chk(!uip_o && !upd_pulse_o, "R1", "reset flags", {uip_o, upd_pulse_o}, 64'd0);
        run_mon = 1'b1;

        // BCD 24h, end of century
        load_all(58, 59, 23, 7, 31, 12, 99, 20);
        tag = "R6 R8";
        predict(3);
        ctl_freeze = 1'b0;
        wait_drain();

        // freeze holds everything
        ctl_freeze = 1'b1; steady = 1'b0;
        repeat (3 * TICKS) @(negedge clk);
        chk(dut_snap() == model_snap(), "R4", "frozen fields", dut_snap(), model_snap());
        chk(!uip_o, "R4", "frozen uip", 64'(uip_o), 64'd0);

        // non-running divider code also holds
        ctl_freeze = 1'b0; ctl_div = 3'b011;
        repeat (3 * TICKS) @(negedge clk);
        chk(dut_snap() == model_snap(), "R4", "stopped code fields", dut_snap(), model_snap());

        // halt, binary 12h, leap February
        ctl_div = 3'b110; ctl_binary = 1'b1; ctl_24h = 1'b0;
        load_all(59, 59, 23, 3, 28, 2, 4, 20);
        repeat (2 * TICKS) @(negedge clk);
        chk(!uip_o, "R5", "uip while halted", 64'(uip_o), 64'd0);
        chk(dut_snap() == model_snap(), "R5", "halted fields", dut_snap(), model_snap());
        tag = "R7 R8";
        predict(2);
        steady = 1'b0;
        ctl_div = 3'b010;
        k = 0;
        for (int i = 0; i < 4 * TICKS; i++) begin
            @(negedge clk);
            k++;
            if (upd_pulse_o) break;
        end
        chk(k == TICKS / 2 + 1, "R5", "first update after halt", 64'(k), 64'(TICKS / 2 + 1));
        wait_drain();

        // non-leap February
        ctl_div = 3'b110; steady = 1'b0;
        load_all(59, 59, 23, 5, 28, 2, 5, 20);
        tag = "R8";
        predict(1);
        ctl_div = 3'b010;
        wait_drain();

        // BCD 12h, morning to noon
        ctl_div = 3'b110; steady = 1'b0; ctl_binary = 1'b0;
        load_all(59, 59, 11, 2, 10, 6, 21, 20);
        chk(hour_o == 8'h11, "R7", "morning hour byte", 64'(hour_o), 64'h11);
        tag = "R7 R6";
        predict(2);
        ctl_div = 3'b010;
        wait_drain();
        chk(hour_o == 8'h92, "R7", "noon hour byte", 64'(hour_o), 64'h92);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule